// File: doc/BRIEF.md
# Undefined-Burst Arbitration Point Tracker

This block sits beside a slave-port arbiter, one copy for each master. It decides when an undefined-length burst from that master may be cut short by arbitration. While the master holds the port, the block counts every beat the port accepts from it. It compares that count with a beat limit chosen by a small configuration code. When an undefined-length beat brings the count to the limit, it raises a registered "open" flag. The arbiter may then hand the port to a competing master of higher priority.

The count runs across back-to-back accesses, so single beats and earlier bursts that lead into an undefined burst count toward its limit. The count restarts only when the master loses the port. After the master regains the port, it must complete a full limit of new beats before an arbitration point appears again. A burst with fewer beats left than the limit finishes without being interrupted. Fixed-length bursts never open the port. They stay locked until their last beat.

Top module: `arbpt_tracker`

## Requirements
- R1: While `rst_n` is low, `openFlag` is 0 and the beat count is cleared at each clock edge.
- R2: `cfgCode` values 1, 2 and 3 select a limit of 4, 8 and 16 beats.
- R3: `cfgCode` 0 and the unused codes 4 to 7 mean no limit, and `openFlag` never rises for them.
- R4: `openFlag` is registered. It goes to 1 in the cycle after an accepted undefined-length beat (`burstKind` = 2'b10) that brings the beat count to the limit or past it.
- R5: Every accepted beat counts while `holdsPort` is 1. This includes single (2'b00), fixed-length (2'b01) and undefined-length beats, and the count carries across burst boundaries.
- R6: Once open, `openFlag` stays 1 on every further accepted undefined-length beat until the port is lost. In cycles with no accepted beat, it keeps its value.
- R7: A clock edge with `holdsPort` at 0 clears both the count and `openFlag`. After the port is regained, a full limit of new beats is needed before `openFlag` rises again.
- R8: An accepted beat that is not undefined-length drives `openFlag` to 0 in the next cycle. This covers fixed-length, single and the unused kind 2'b11.
- R9: The count saturates at the selected limit. After a switch to a larger limit, the beats already counted add only up to the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| holdsPort | input | 1 | The arbiter currently grants the port to this master |
| beatValid | input | 1 | A beat from this master is accepted this cycle |
| burstKind | input | 2 | Kind of the current beat: 00 single, 01 fixed-length, 10 undefined-length, 11 treated as single |
| cfgCode | input | 3 | Limit select: 1/2/3 give 4/8/16 beats, others give no limit |
| openFlag | output | 1 | Arbitration may interrupt this master's undefined-length burst |

## Verification
The assertions assume that `beatValid` is only meaningful while `holdsPort` is 1. A beat seen without the port is ignored, and the block simply clears. They also assume that `cfgCode` and `burstKind` are sampled only at accepted beats. The random stimulus keeps `holdsPort` high most of the time, so that counts build to the limits. It also drops the port now and then, mixes every burst kind, and changes `cfgCode` at random points, including between beats of one burst, which the assertions allow. Directed sequences cover carry-over from single beats, regaining the port mid-burst, and saturation under a growing limit.

// File: rtl/arbpt_pkg.sv
package arbpt_pkg;

  // Kind of the beat presented with beatValid
  typedef enum logic [1:0] {
    BK_SINGLE = 2'b00,
    BK_FIXED  = 2'b01,
    BK_UNDEF  = 2'b10,
    BK_RSVD   = 2'b11
  } burstKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;          // port not held: wipe count and flag
    logic advance;        // an accepted beat while port held
    logic openCandidate;  // that beat may open arbitration
    logic limitValid;     // a real limit is selected
  } ctrlStrobes_t;

endpackage

// File: rtl/arbpt_ctrl.sv
module arbpt_ctrl
  import arbpt_pkg::*;
#(
  parameter int CFG_W     = 3,
  parameter int BASE_LOG2 = 2,
  parameter int NUM_CODES = 3,
  parameter int CNT_W     = BASE_LOG2 + NUM_CODES
) (
  input  logic             holdsPort,
  input  logic             beatValid,
  input  burstKind_t       burstKind,
  input  logic [CFG_W-1:0] cfgCode,
  output ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] beatLimit
);

  // Code i (1..NUM_CODES) selects 2**(BASE_LOG2+i-1) beats; all else none
  always_comb begin
    beatLimit = '0;
    for (int i = 1; i <= NUM_CODES; i++) begin
      if (cfgCode == CFG_W'(i)) begin
        beatLimit = CNT_W'(1) << (BASE_LOG2 + i - 1);
      end
    end
  end

  logic undefBeat;
  logic haveLimit;

  assign undefBeat = (burstKind == BK_UNDEF);
  assign haveLimit = (beatLimit != '0);

  always_comb begin
    strobes.clear         = !holdsPort;
    strobes.advance       = holdsPort && beatValid;
    strobes.openCandidate = undefBeat && haveLimit;
    strobes.limitValid    = haveLimit;
  end

endmodule

// File: rtl/arbpt_dp.sv
module arbpt_dp
  import arbpt_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [CNT_W-1:0] beatLimit,
  output logic [CNT_W-1:0] beatCount,
  output logic             openFlag
);

  logic [CNT_W-1:0] countCap;
  logic [CNT_W-1:0] countNext;
  logic             reachNext;

  // Saturate at the limit, or at all-ones when no limit applies
  assign countCap  = strobes.limitValid ? beatLimit : '1;
  assign countNext = (beatCount >= countCap) ? countCap : beatCount + CNT_W'(1);
  assign reachNext = strobes.openCandidate && (countNext >= beatLimit);

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clear) begin
      beatCount <= '0;
      openFlag  <= 1'b0;
    end else if (strobes.advance) begin
      beatCount <= countNext;
      openFlag  <= reachNext;
    end
  end

endmodule

// File: rtl/arbpt_tracker.sv
module arbpt_tracker
  import arbpt_pkg::*;
#(
  parameter int CFG_W     = 3,
  parameter int BASE_LOG2 = 2,
  parameter int NUM_CODES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             holdsPort,
  input  logic             beatValid,
  input  logic [1:0]       burstKind,
  input  logic [CFG_W-1:0] cfgCode,
  output logic             openFlag
);

  localparam int CNT_W = BASE_LOG2 + NUM_CODES;

  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] beatLimit;
  logic [CNT_W-1:0] beatCount;
  burstKind_t       kindTyped;

  assign kindTyped = burstKind_t'(burstKind);

  arbpt_ctrl #(
    .CFG_W    (CFG_W),
    .BASE_LOG2(BASE_LOG2),
    .NUM_CODES(NUM_CODES),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .holdsPort(holdsPort),
    .beatValid(beatValid),
    .burstKind(kindTyped),
    .cfgCode  (cfgCode),
    .strobes  (strobes),
    .beatLimit(beatLimit)
  );

  arbpt_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .beatLimit(beatLimit),
    .beatCount(beatCount),
    .openFlag (openFlag)
  );

endmodule

// File: rtl/arbpt_checker.sv
module arbpt_checker #(
  parameter int CFG_W     = 3,
  parameter int BASE_LOG2 = 2,
  parameter int NUM_CODES = 3,
  parameter int CNT_W     = BASE_LOG2 + NUM_CODES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             holdsPort,
  input logic             beatValid,
  input logic [1:0]       burstKind,
  input logic [CFG_W-1:0] cfgCode,
  input logic             openFlag,
  input logic [CNT_W-1:0] beatCount
);

  logic             codeValid;
  logic [CNT_W-1:0] chkLimit;

  assign codeValid = (cfgCode >= CFG_W'(1)) && (cfgCode <= CFG_W'(NUM_CODES));
  always_comb begin
    chkLimit = '0;
    for (int i = 1; i <= NUM_CODES; i++)
      if (cfgCode == CFG_W'(i)) chkLimit = CNT_W'(1) << (BASE_LOG2 + i - 1);
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!openFlag && beatCount == '0));

  assert_no_limit_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (holdsPort && beatValid && !codeValid) |=> !openFlag);

  assert_open_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(openFlag) |-> $past(holdsPort && beatValid && burstKind == 2'b10));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (holdsPort && !beatValid) |=> $stable(openFlag));

  assert_loss_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !holdsPort |=> (!openFlag && beatCount == '0));

  assert_locked_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (holdsPort && beatValid && burstKind != 2'b10) |=> !openFlag);

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (holdsPort && beatValid && codeValid) |=> (beatCount <= $past(chkLimit)));

endmodule

bind arbpt_tracker arbpt_checker #(
  .CFG_W    (CFG_W),
  .BASE_LOG2(BASE_LOG2),
  .NUM_CODES(NUM_CODES),
  .CNT_W    (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .holdsPort(holdsPort),
  .beatValid(beatValid),
  .burstKind(burstKind),
  .cfgCode  (cfgCode),
  .openFlag (openFlag),
  .beatCount(beatCount)
);

// File: tb/sim_arbpt_tracker.sv
module sim_arbpt_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       holdsPort = 1'b0;
  logic       beatValid = 1'b0;
  logic [1:0] burstKind = 2'b00;
  logic [2:0] cfgCode = 3'd0;
  logic       openFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // bench model state
  int modCount = 0;
  bit modFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arbpt_tracker u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .holdsPort(holdsPort),
    .beatValid(beatValid),
    .burstKind(burstKind),
    .cfgCode  (cfgCode),
    .openFlag (openFlag)
  );

  // R2/R3: limit from code
  function automatic int limitOf(input logic [2:0] c);
    case (c)
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic void modelStep(input bit h, input bit b, input logic [1:0] k,
                                    input logic [2:0] c);
    int lim, cap, nxt;
    if (!h) begin
      modCount = 0;
      modFlag  = 1'b0;
    end else if (b) begin
      lim = limitOf(c);
      cap = (lim == 0) ? 31 : lim;
      nxt = (modCount >= cap) ? cap : modCount + 1;
      modFlag  = (k == 2'b10) && (lim != 0) && (nxt >= lim);
      modCount = nxt;
    end
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: openFlag actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, compare at the following negedge
  task automatic step(input bit h, input bit b, input logic [1:0] k,
                      input logic [2:0] c, input string req);
    holdsPort = h;
    beatValid = b;
    burstKind = k;
    cfgCode   = c;
    modelStep(h, b, k, c);
    @(posedge clk);
    @(negedge clk);
    check(openFlag, modFlag, req);
  endtask

  task automatic expectNow(input bit exp, input string req);
    check(openFlag, exp, req);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset
    rst_n = 1'b0;
    holdsPort = 1'b1; beatValid = 1'b1; burstKind = 2'b10; cfgCode = 3'd1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    expectNow(1'b0, "R1");
    rst_n = 1'b1;
    modCount = 0; modFlag = 1'b0;

    // R5: two singles then undefined burst, limit 4 opens at its second beat
    step(1, 1, 2'b00, 3'd1, "R5");
    step(1, 1, 2'b00, 3'd1, "R5");
    step(1, 1, 2'b10, 3'd1, "R5");
    expectNow(1'b0, "R5");
    step(1, 1, 2'b10, 3'd1, "R4");
    expectNow(1'b1, "R4");
    // R6: stays open, holds over idle
    step(1, 1, 2'b10, 3'd1, "R6");
    step(1, 0, 2'b10, 3'd1, "R6");
    expectNow(1'b1, "R6");
    // R7: lose port, regain, need four new beats
    step(0, 0, 2'b10, 3'd1, "R7");
    expectNow(1'b0, "R7");
    for (int i = 0; i < 3; i++) step(1, 1, 2'b10, 3'd1, "R7");
    expectNow(1'b0, "R7");
    step(1, 1, 2'b10, 3'd1, "R7");
    expectNow(1'b1, "R7");
    // R8: fixed beat locks
    step(1, 1, 2'b01, 3'd1, "R8");
    expectNow(1'b0, "R8");
    step(1, 1, 2'b11, 3'd1, "R8");
    expectNow(1'b0, "R8");
    // R7: two beats left after regain finish without opening
    step(0, 0, 2'b10, 3'd1, "R7");
    step(1, 1, 2'b10, 3'd1, "R7");
    step(1, 1, 2'b10, 3'd1, "R7");
    expectNow(1'b0, "R7");

    // R3: no-limit codes never open
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      step(0, 0, 2'b10, 3'(c), "R3");
      for (int i = 0; i < 20; i++) step(1, 1, 2'b10, 3'(c), "R3");
      expectNow(1'b0, "R3");
    end

    // R2: limits 8 and 16
    step(0, 0, 2'b10, 3'd2, "R2");
    for (int i = 0; i < 7; i++) step(1, 1, 2'b10, 3'd2, "R2");
    expectNow(1'b0, "R2");
    step(1, 1, 2'b10, 3'd2, "R2");
    expectNow(1'b1, "R2");
    step(0, 0, 2'b10, 3'd3, "R2");
    for (int i = 0; i < 15; i++) step(1, 1, 2'b10, 3'd3, "R2");
    expectNow(1'b0, "R2");
    step(1, 1, 2'b10, 3'd3, "R2");
    expectNow(1'b1, "R2");

    // R9: saturate at 4, then widen to 8: four more beats needed
    step(0, 0, 2'b10, 3'd1, "R9");
    for (int i = 0; i < 10; i++) step(1, 1, 2'b10, 3'd1, "R9");
    for (int i = 0; i < 3; i++) step(1, 1, 2'b10, 3'd2, "R9");
    expectNow(1'b0, "R9");
    step(1, 1, 2'b10, 3'd2, "R9");
    expectNow(1'b1, "R9");

    // random mix (R4, R5, R6, R7, R8)
    for (int n = 0; n < 4000; n++) begin
      bit h, b;
      logic [1:0] k;
      logic [2:0] c;
      h = ($urandom_range(0, 19) != 0);
      b = ($urandom_range(0, 3) != 0);
      k = 2'($urandom_range(0, 9) < 7 ? 2 : $urandom_range(0, 3));
      c = (n % 97 == 0) ? 3'($urandom_range(0, 7)) : cfgCode;
      step(h, b, k, c, "R4");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule